// File: doc/BRIEF.md
# Integer ALU With Set-Condition

This block is the integer execute stage of a 32-bit load-store processor, built as pure combinational logic. Each evaluation takes a first operand A, a second operand that comes either from a register (B) or from a 16-bit immediate, and an operation code. It returns a 32-bit result and a signed-overflow flag. The operations are addition and subtraction in signed and unsigned forms, bitwise AND, OR and XOR, three kinds of shift, placement of an immediate in the upper half of the word, and comparisons. A comparison writes the value 1 or 0 as the result instead of updating a condition-code register.

The pipeline places the block between operand fetch and write-back. The decoder supplies the operation code, the relation code for comparisons, and the flag that selects the immediate. The block decides how the immediate is widened. Signed arithmetic and signed comparisons sign-extend it. Every other operation zero-extends it.

Top module: `alu_int_exec`

## Requirements
- R1: Signed add (op code 0) returns A plus operand B, and signed subtract (op code 2) returns A minus operand B, both modulo 2^32. When use_imm_i is 1, operand B is the sign-extended 16-bit immediate.
- R2: Unsigned add (op code 1) and unsigned subtract (op code 3) return A plus or minus operand B modulo 2^32. When use_imm_i is 1, operand B is the zero-extended immediate.
- R3: ovf_o is 1 exactly when a signed add or a signed subtract overflows in two's complement. It is 0 for every other op code, including the unsigned add and subtract.
- R4: AND (op code 4), OR (op code 5) and XOR (op code 6) combine A with operand B bit by bit. When use_imm_i is 1, operand B is the zero-extended immediate.
- R5: Shift-left-logical (op code 7) and shift-right-logical (op code 8) shift A and fill with zeros. The shift amount is bits 4:0 of B, or bits 4:0 of the immediate when use_imm_i is 1. All higher amount bits are ignored.
- R6: Shift-right-arithmetic (op code 9) shifts A right by the same 5-bit amount and fills the vacated bits with bit 31 of A.
- R7: Load-high (op code 10) returns the immediate in bits 31:16 and zero in bits 15:0. A, B and use_imm_i have no effect on it.
- R8: Signed set (op code 11) returns 1 when the relation selected by cond_i holds between signed A and signed operand B, and 0 otherwise. The immediate is sign-extended. cond_i encodes 0 = equal, 1 = not equal, 2 = less, 3 = greater, 4 = less-or-equal, 5 = greater-or-equal.
- R9: Unsigned set (op code 12) uses the same cond_i encoding and the same 0/1 result as R8, but compares A and operand B as unsigned numbers with a zero-extended immediate.
- R10: Op codes 13 to 15, and cond_i values 6 and 7 with either set operation, give a result of 0 and ovf_o of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | Use the immediate in place of b_i |
| op_i | input | 4 | Operation code |
| cond_i | input | 3 | Relation code for the set operations |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of a signed add or subtract |

## Verification
The block holds no state, so any internal fault shows at result_o or ovf_o in the same evaluation as the inputs that expose it. The faults this covers include a wrong immediate extension, a bad barrel-shifter stage, a comparator that uses the wrong signedness, and an overflow term raised on an unsigned operation. The sweep pairs boundary operands (zero, one, the most positive value, the most negative value, all ones) with boundary immediates (0x7FFF, 0x8000, 0xFFFF, shift amounts of 31 and 32). It runs every op code under both operand sources, so each such fault changes at least one sampled output.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9,
        OP_LHI  = 4'd10,
        OP_SETS = 4'd11,
        OP_SETU = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        CND_EQ = 3'd0,
        CND_NE = 3'd1,
        CND_LT = 3'd2,
        CND_GT = 3'd3,
        CND_LE = 3'd4,
        CND_GE = 3'd5
    } alu_cond_e;

    typedef struct packed {
        logic subtract;
        logic signed_ovf;
        logic imm_sext;
        logic cmp_signed;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_ctl(input logic [3:0] op);
        alu_ctl_t c;
        c.subtract   = (op == OP_SUB) || (op == OP_SUBU);
        c.signed_ovf = (op == OP_ADD) || (op == OP_SUB);
        c.imm_sext   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_SETS);
        c.cmp_signed = (op == OP_SETS);
        return c;
    endfunction

endpackage

// File: rtl/alu_opb_sel.sv
module alu_opb_sel #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             sext_i,
    output logic [W-1:0]     opb_o
);
    localparam int EXT_W = W - IMM_W;

    logic [EXT_W-1:0] ext_bits;

    always_comb begin
        ext_bits = sext_i ? {EXT_W{imm_i[IMM_W-1]}} : {EXT_W{1'b0}};
        opb_o    = use_imm_i ? {ext_bits, imm_i} : b_i;
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         chk_ovf_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        ovf_o = chk_ovf_i && (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    input  logic [2:0]   cond_i,
    output logic         hit_o
);
    import alu_pkg::*;

    logic eq;
    logic lt;

    always_comb begin
        eq = (a_i == b_i);
        lt = signed_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
        case (cond_i)
            CND_EQ:  hit_o = eq;
            CND_NE:  hit_o = !eq;
            CND_LT:  hit_o = lt;
            CND_GT:  hit_o = !lt && !eq;
            CND_LE:  hit_o = lt || eq;
            CND_GE:  hit_o = !lt;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  logic                 left_i,
    input  logic                 arith_i,
    output logic [W-1:0]         res_o
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0] a_rev;
    logic [W-1:0] stage [0:SH_W];
    logic [W-1:0] out_rev;
    logic         fill;

    assign fill = arith_i && !left_i && a_i[W-1];

    for (genvar k = 0; k < W; k++) begin : g_rev
        assign a_rev[k]   = a_i[W-1-k];
        assign out_rev[k] = stage[SH_W][W-1-k];
    end

    assign stage[0] = left_i ? a_rev : a_i;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? {{(1 << s){fill}}, stage[s][W-1:(1 << s)]}
                                     : stage[s];
    end

    assign res_o = left_i ? out_rev : stage[SH_W];
endmodule

// File: rtl/alu_int_exec.sv
module alu_int_exec #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic [3:0]       op_i,
    input  logic [2:0]       cond_i,
    output logic [W-1:0]     result_o,
    output logic             ovf_o
);
    import alu_pkg::*;

    localparam int SH_W = $clog2(W);

    alu_ctl_t     ctl;
    logic [W-1:0] opb;
    logic [W-1:0] sum;
    logic         add_ovf;
    logic         set_hit;
    logic [W-1:0] shifted;

    assign ctl = decode_ctl(op_i);

    alu_opb_sel #(.W(W), .IMM_W(IMM_W)) u_opb (
        .b_i       (b_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .sext_i    (ctl.imm_sext),
        .opb_o     (opb)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a_i       (a_i),
        .b_i       (opb),
        .sub_i     (ctl.subtract),
        .chk_ovf_i (ctl.signed_ovf),
        .sum_o     (sum),
        .ovf_o     (add_ovf)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a_i      (a_i),
        .b_i      (opb),
        .signed_i (ctl.cmp_signed),
        .cond_i   (cond_i),
        .hit_o    (set_hit)
    );

    alu_shift #(.W(W)) u_shift (
        .a_i     (a_i),
        .amt_i   (opb[SH_W-1:0]),
        .left_i  (op_i == OP_SLL),
        .arith_i (op_i == OP_SRA),
        .res_o   (shifted)
    );

    always_comb begin
        ovf_o = add_ovf;
        case (op_i)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
            OP_AND:                           result_o = a_i & opb;
            OP_OR:                            result_o = a_i | opb;
            OP_XOR:                           result_o = a_i ^ opb;
            OP_SLL, OP_SRL, OP_SRA:           result_o = shifted;
            OP_LHI:                           result_o = {imm_i, {(W-IMM_W){1'b0}}};
            OP_SETS, OP_SETU:                 result_o = {{(W-1){1'b0}}, set_hit};
            default:                          result_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_int_exec_chk.sv
module alu_int_exec_chk #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input logic [W-1:0]     a_i,
    input logic [W-1:0]     b_i,
    input logic [IMM_W-1:0] imm_i,
    input logic             use_imm_i,
    input logic [3:0]       op_i,
    input logic [2:0]       cond_i,
    input logic [W-1:0]     result_o,
    input logic             ovf_o
);
    always_comb begin
        if (op_i != 4'd0 && op_i != 4'd2) begin
            p_no_overflow_r3: assert (!ovf_o)
                else $error("ovf_o raised by op %0d", op_i);
        end
        if (op_i == 4'd10) begin
            p_lhi_place_r7: assert (result_o == {imm_i, {(W-IMM_W){1'b0}}})
                else $error("load-high result %h", result_o);
        end
        if (op_i == 4'd11 || op_i == 4'd12) begin
            p_set_binary_r8: assert (result_o[W-1:1] == '0)
                else $error("set result not 0/1: %h", result_o);
        end
        if (op_i == 4'd9) begin
            p_sra_sign_r6: assert (result_o[W-1] == a_i[W-1])
                else $error("arithmetic shift lost sign");
        end
        if (op_i > 4'd12 || ((op_i == 4'd11 || op_i == 4'd12) && cond_i > 3'd5)) begin
            p_bad_code_r10: assert (result_o == '0 && !ovf_o)
                else $error("unused code gave %h", result_o);
        end
        if (op_i == 4'd0 && !use_imm_i && a_i[W-1] != b_i[W-1]) begin
            p_mixed_sign_add_r3: assert (!ovf_o)
                else $error("overflow on mixed-sign add");
        end
    end
endmodule

bind alu_int_exec alu_int_exec_chk #(.W(W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/alu_int_exec_bench.sv
module alu_int_exec_bench;

    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic        ui;
    logic [3:0]  op;
    logic [2:0]  cond;
    logic [31:0] res;
    logic        ovf;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    logic [31:0] av [0:7];
    logic [31:0] bv [0:7];
    logic [15:0] iv [0:7];

    always #(CYC/2) clk = ~clk;

    alu_int_exec u_alu_int_exec (
        .a_i       (a),
        .b_i       (b),
        .imm_i     (imm),
        .use_imm_i (ui),
        .op_i      (op),
        .cond_i    (cond),
        .result_o  (res),
        .ovf_o     (ovf)
    );

    function automatic string req_of(input logic [3:0] o, input logic [2:0] c);
        case (o)
            4'd0, 4'd2:        return "R1";
            4'd1, 4'd3:        return "R2";
            4'd4, 4'd5, 4'd6:  return "R4";
            4'd7, 4'd8:        return "R5";
            4'd9:              return "R6";
            4'd10:             return "R7";
            4'd11:             return (c > 3'd5) ? "R10" : "R8";
            4'd12:             return (c > 3'd5) ? "R10" : "R9";
            default:           return "R10";
        endcase
    endfunction

    function automatic logic rel(input logic lt, input logic eq, input logic [2:0] c);
        case (c)
            3'd0: return eq;
            3'd1: return !eq;
            3'd2: return lt;
            3'd3: return !lt && !eq;
            3'd4: return lt || eq;
            3'd5: return !lt;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model(output logic [31:0] er, output logic eo);
        logic [31:0] bs, bz;
        longint      w;
        bs = ui ? {{16{imm[15]}}, imm} : b;
        bz = ui ? {16'h0, imm} : b;
        eo = 1'b0;
        er = 32'h0;
        case (op)
            4'd0: begin
                er = a + bs;
                w  = longint'($signed(a)) + longint'($signed(bs));
                eo = (w > 64'sd2147483647) || (w < -64'sd2147483648);
            end
            4'd2: begin
                er = a - bs;
                w  = longint'($signed(a)) - longint'($signed(bs));
                eo = (w > 64'sd2147483647) || (w < -64'sd2147483648);
            end
            4'd1:  er = a + bz;
            4'd3:  er = a - bz;
            4'd4:  er = a & bz;
            4'd5:  er = a | bz;
            4'd6:  er = a ^ bz;
            4'd7:  er = a << bz[4:0];
            4'd8:  er = a >> bz[4:0];
            4'd9:  er = $unsigned($signed(a) >>> bz[4:0]);
            4'd10: er = {imm, 16'h0};
            4'd11: er = {31'h0, rel($signed(a) < $signed(bs), a == bs, cond)};
            4'd12: er = {31'h0, rel(a < bz, a == bz, cond)};
            default: er = 32'h0;
        endcase
    endtask

    task automatic check_now();
        logic [31:0] er;
        logic        eo;
        model(er, eo);
        checks++;
        if (res !== er) begin
            failures++;
            $display("FAIL %s op=%0d cond=%0d a=%h b=%h imm=%h ui=%0d result=%h expected=%h",
                     req_of(op, cond), op, cond, a, b, imm, ui, res, er);
        end
        checks++;
        if (ovf !== eo) begin
            failures++;
            $display("FAIL R3 op=%0d a=%h b=%h imm=%h ui=%0d ovf=%0d expected=%0d",
                     op, a, b, imm, ui, ovf, eo);
        end
    endtask

    initial begin
        #(CYC * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        av[0] = 32'h0000_0000; av[1] = 32'h0000_0001; av[2] = 32'h7FFF_FFFF; av[3] = 32'h8000_0000;
        av[4] = 32'hFFFF_FFFF; av[5] = 32'h1234_5678; av[6] = 32'h8000_7FFF; av[7] = 32'hFFFF_8000;
        bv[0] = 32'h0000_0000; bv[1] = 32'h0000_0001; bv[2] = 32'h7FFF_FFFF; bv[3] = 32'h8000_0000;
        bv[4] = 32'hFFFF_FFFF; bv[5] = 32'h0000_001F; bv[6] = 32'hFFFF_FFE4; bv[7] = 32'h1234_5678;
        iv[0] = 16'h0000; iv[1] = 16'h0001; iv[2] = 16'h7FFF; iv[3] = 16'h8000;
        iv[4] = 16'hFFFF; iv[5] = 16'h001F; iv[6] = 16'h0020; iv[7] = 16'h5678;

        a = '0; b = '0; imm = '0; ui = 1'b0; op = '0; cond = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: zero inputs give a zero sum and no overflow (R1, R3)
        @(negedge clk);
        #2;
        check_now();

        for (int o = 0; o < 16; o++) begin
            int nc;
            nc = (o == 11 || o == 12) ? 8 : 1;
            for (int c = 0; c < nc; c++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int ia = 0; ia < 8; ia++) begin
                        for (int ib = 0; ib < 8; ib++) begin
                            for (int ii = 0; ii < 8; ii++) begin
                                @(negedge clk);
                                op   = 4'(o);
                                cond = (nc == 8) ? 3'(c) : 3'(ia);
                                ui   = u[0];
                                a    = av[ia];
                                b    = bv[ib];
                                imm  = iv[ii];
                                #5;
                                check_now();
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule